// File: doc/BRIEF.md
# Per-Token Symmetric INT8 Activation Quantizer

This block turns one token's vector of signed fixed-point activations into signed 8-bit codes. The scale is taken from that token alone. Elements arrive on a valid/ready stream, and a last flag closes each token. The block stores the token while it tracks the largest magnitude seen. It then divides each stored element by that magnitude and sends the 8-bit results out on a second valid/ready stream, with a last flag on the final element.

The mapping is symmetric, and no zero point is applied. Each output is 127·x / amax, rounded half away from zero and held to the range -127..+127. The scale is reported as its numerator, the token's absolute maximum `amax`, so that the real scale is amax / 127. A zero-scale flag marks a token whose elements are all zero.

Tokens longer than the buffer are discarded, and an error pulse reports the discard. Input and output phases take turns: while a token is being emitted, the input side is not ready.

Top module: `act_token_quant`

## Requirements
- R1: `scale_amax` equals the largest |x| over the token's elements. An input of -2^(IN_W-1) counts as magnitude 2^(IN_W-1). The value is presented with every output element of the token and does not change until the token's last element has been taken.
- R2: Each output element equals round(127·x / amax), rounded half away from zero, with the sign of x. For example, with amax 254, an input of 1 gives 1, an input of -3 gives -2, and an input of 2 gives 1.
- R3: Every output element lies in -127..+127. The code -128 (8'h80) never appears, and the most negative input maps to -127.
- R4: A token whose elements are all zero produces only zero codes, with `scale_zero` = 1. Any other token has `scale_zero` = 0.
- R5: A token with more than DEPTH elements produces no output elements. `ovf_err` goes high for exactly one cycle, in the cycle after that token's last element is accepted, and the input is ready again in that same cycle.
- R6: A token with exactly DEPTH elements is quantized in full, like any shorter token.
- R7: Output elements leave in the order they arrived, one per input element. `out_last` is high only on the final one. After the final one is taken, `in_ready` returns to 1.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `scale_amax` hold their values.
- R9: After reset, `in_ready` = 1, `out_valid` = 0 and `ovf_err` = 0. From the acceptance of a token's last element until its final output is taken, `in_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block accepts an input element |
| in_data | input | IN_W | Signed two's-complement activation |
| in_last | input | 1 | Marks the token's final element |
| out_valid | output | 1 | Quantized element present |
| out_ready | input | 1 | Consumer takes the element |
| out_data | output | 8 | Signed quantized code |
| out_last | output | 1 | Marks the token's final code |
| scale_amax | output | IN_W | Token absolute maximum (scale = value / 127) |
| scale_zero | output | 1 | Token was all zero |
| ovf_err | output | 1 | One-cycle pulse: oversize token dropped |

## Verification
The hardest situation to reach from the ports is a result that sits exactly halfway between two codes. It only occurs for particular pairs of element and token maximum, so the stimulus table includes a token whose maximum is 254; there, odd small inputs land on a .5 boundary in both signs. Two further cases need a token that is exactly DEPTH elements long and then one that is a single element longer, each followed by a normal token. These show where the buffer-full decision falls and that the block recovers after a dropped token. Held-output behaviour is reached by withdrawing `out_ready` on alternate elements.

// File: rtl/aq_pkg.sv
package aq_pkg;
    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_DIV  = 2'd1,
        ST_OUT  = 2'd2
    } aq_state_e;

    localparam int QLIM   = 127;
    localparam int CODE_W = 8;
endpackage

// File: rtl/aq_tok_buf.sv
module aq_tok_buf #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/aq_rdiv.sv
module aq_rdiv #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 17,
    localparam int CW   = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    typedef struct packed {
        logic [DEN_W:0]   rem;
        logic [NUM_W-1:0] acc;
        logic [DEN_W-1:0] dv;
        logic [CW-1:0]    cnt;
        logic             done;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] trial;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem[DEN_W-1:0], q.acc[NUM_W-1]};
        if (start) begin
            d.rem = '0;
            d.acc = num;
            d.dv  = den;
            d.cnt = CW'(NUM_W);
        end else if (q.cnt != '0) begin
            if (trial >= {1'b0, q.dv}) begin
                d.rem = trial - {1'b0, q.dv};
                d.acc = {q.acc[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = trial;
                d.acc = {q.acc[NUM_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign quo  = q.acc;
endmodule

// File: rtl/aq_rsat.sv
module aq_rsat #(
    parameter int NUM_W = 24
) (
    input  logic [NUM_W-1:0] mag_in,
    input  logic             neg,
    output logic [7:0]       code
);
    logic [6:0] mag_d;
    logic [7:0] pos_d;

    always_comb begin
        if (mag_in > NUM_W'(aq_pkg::QLIM)) begin
            mag_d = 7'd127;
        end else begin
            mag_d = mag_in[6:0];
        end
        pos_d = {1'b0, mag_d};
        code  = neg ? (~pos_d + 8'd1) : pos_d;
    end
endmodule

// File: rtl/act_token_quant.sv
module act_token_quant #(
    parameter int IN_W  = 16,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IN_W-1:0] in_data,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [7:0]      out_data,
    output logic            out_last,
    output logic [IN_W-1:0] scale_amax,
    output logic            scale_zero,
    output logic            ovf_err
);
    import aq_pkg::*;

    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NUM_W = IN_W + 8;
    localparam int DEN_W = IN_W + 1;

    typedef struct packed {
        aq_state_e        state;
        logic [CNT_W-1:0] wr_cnt;
        logic             ovf;
        logic [IN_W-1:0]  run_max;
        logic [IN_W-1:0]  tok_max;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] idx;
        logic             pend;
        logic             neg;
        logic [7:0]       odata;
        logic             err;
    } ctl_t;

    ctl_t q, d;

    logic             in_fire;
    logic             buf_full;
    logic             wr_en;
    logic [IN_W-1:0]  in_mag;
    logic [IN_W-1:0]  run_next;
    logic [IN_W-1:0]  rd_data;
    logic [IN_W-1:0]  rd_mag;
    logic             div_start;
    logic             div_done;
    logic [NUM_W-1:0] div_num;
    logic [DEN_W-1:0] div_den;
    logic [NUM_W-1:0] div_quo;
    logic [7:0]       sat_code;

    assign in_fire   = in_valid && (q.state == ST_FILL);
    assign buf_full  = (q.wr_cnt == CNT_W'(DEPTH));
    assign wr_en     = in_fire && !buf_full;
    assign in_mag    = in_data[IN_W-1] ? (~in_data + 1'b1) : in_data;
    assign run_next  = (in_mag > q.run_max) ? in_mag : q.run_max;
    assign rd_mag    = rd_data[IN_W-1] ? (~rd_data + 1'b1) : rd_data;
    assign div_start = (q.state == ST_DIV) && q.pend && (q.tok_max != '0);
    assign div_num   = NUM_W'(rd_mag) * NUM_W'(2 * QLIM) + NUM_W'(q.tok_max);
    assign div_den   = {q.tok_max, 1'b0};

    aq_tok_buf #(
        .W     (IN_W),
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (q.wr_cnt[AW-1:0]),
        .wr_data (in_data),
        .rd_addr (q.idx[AW-1:0]),
        .rd_data (rd_data)
    );

    aq_rdiv #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    aq_rsat #(
        .NUM_W (NUM_W)
    ) u_sat (
        .mag_in (div_quo),
        .neg    (q.neg),
        .code   (sat_code)
    );

    always_comb begin
        d     = q;
        d.err = 1'b0;
        unique case (q.state)
            ST_FILL: begin
                if (in_fire) begin
                    d.run_max = run_next;
                    if (buf_full) begin
                        d.ovf = 1'b1;
                    end else begin
                        d.wr_cnt = q.wr_cnt + 1'b1;
                    end
                    if (in_last) begin
                        d.wr_cnt  = '0;
                        d.ovf     = 1'b0;
                        d.run_max = '0;
                        if (q.ovf || buf_full) begin
                            d.err = 1'b1;
                        end else begin
                            d.len     = q.wr_cnt + 1'b1;
                            d.tok_max = run_next;
                            d.idx     = '0;
                            d.pend    = 1'b1;
                            d.state   = ST_DIV;
                        end
                    end
                end
            end
            ST_DIV: begin
                if (q.pend) begin
                    d.pend = 1'b0;
                    d.neg  = rd_data[IN_W-1];
                    if (q.tok_max == '0) begin
                        d.odata = '0;
                        d.state = ST_OUT;
                    end
                end else if (div_done) begin
                    d.odata = sat_code;
                    d.state = ST_OUT;
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    if ((q.idx + 1'b1) == q.len) begin
                        d.state = ST_FILL;
                    end else begin
                        d.idx   = q.idx + 1'b1;
                        d.pend  = 1'b1;
                        d.state = ST_DIV;
                    end
                end
            end
            default: begin
                d.state = ST_FILL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready   = (q.state == ST_FILL);
    assign out_valid  = (q.state == ST_OUT);
    assign out_data   = q.odata;
    assign out_last   = out_valid && ((q.idx + 1'b1) == q.len);
    assign scale_amax = q.tok_max;
    assign scale_zero = (q.tok_max == '0);
    assign ovf_err    = q.err;
endmodule

// File: rtl/aq_quant_chk.sv
module aq_quant_chk #(
    parameter int IN_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [IN_W-1:0] in_data,
    input logic            in_last,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_data,
    input logic            out_last,
    input logic [IN_W-1:0] scale_amax,
    input logic            scale_zero,
    input logic            ovf_err
);
    // R8: a stalled element is held
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_last) && $stable(scale_amax));

    // R3: code -128 never leaves the block
    a_r3_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data != 8'h80);

    // R4: a zero-scale token emits only zero codes
    a_r4_zero_codes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && scale_zero |-> out_data == 8'h00);

    // R9: input and output phases never overlap
    a_r9_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R5: a dropped token gives no output, and the input is open again
    a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> !out_valid && in_ready);

    // R5: the error lasts a single cycle
    a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> !ovf_err);

    // R1: the scale stays fixed between elements of a token
    a_r1_scale_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> $stable(scale_amax) && $stable(scale_zero));

    // R7: taking the final element reopens the input
    a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> in_ready && !out_valid);
endmodule

bind act_token_quant aq_quant_chk #(.IN_W(IN_W)) u_chk (.*);

// File: tb/act_token_quant_tb_top.sv
module act_token_quant_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 16;
    localparam int DEPTH      = 16;
    localparam int NV         = 20;
    localparam int WD_LIMIT   = 150000;

    typedef struct packed {
        logic lst;
        int   x;
        int   e;
    } vec_t;

    // R2/R3/R4 vectors: {last, input, expected code}
    localparam vec_t VEC [NV] = '{
        '{1'b0,  100,  127}, '{1'b0,  -50,  -64}, '{1'b0,   25,   32}, '{1'b1, -100, -127},
        '{1'b0,    1,  127}, '{1'b0,   -1, -127}, '{1'b1,    0,    0},
        '{1'b0, -32768, -127}, '{1'b0, 32767, 127}, '{1'b0, 16384,  64}, '{1'b1,   -1,    0},
        '{1'b0,    0,    0}, '{1'b0,    0,    0}, '{1'b1,    0,    0},
        '{1'b1,   -7, -127},
        '{1'b0,    1,    1}, '{1'b0,   -1,   -1}, '{1'b0,    3,    2}, '{1'b0,   -3,   -2},
        '{1'b1,  254,  127}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [IN_W-1:0] in_data = '0;
    logic            in_last = 1'b0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [7:0]      out_data;
    logic            out_last;
    logic [IN_W-1:0] scale_amax;
    logic            scale_zero;
    logic            ovf_err;

    int n_chk  = 0;
    int n_fail = 0;
    int err_seen = 0;
    int outs_seen = 0;
    int tx [0:31];
    int te [0:31];

    always #(CLK_PERIOD / 2) clk = ~clk;

    act_token_quant #(
        .IN_W  (IN_W),
        .DEPTH (DEPTH)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_last    (in_last),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .scale_amax (scale_amax),
        .scale_zero (scale_zero),
        .ovf_err    (ovf_err)
    );

    always @(negedge clk) begin
        if (ovf_err) err_seen++;
        if (out_valid) outs_seen++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mdl(input int x, input int amax);
        longint mag, qv;
        if (amax == 0) return 0;
        mag = (x < 0) ? -x : x;
        qv  = (254 * mag + amax) / (2 * amax);
        if (qv > 127) qv = 127;
        return (x < 0) ? -int'(qv) : int'(qv);
    endfunction

    task automatic send_tok(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = tx[k][IN_W-1:0];
            in_last  = (k == n - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_tok(input int n, input bit stall);
        int amax;
        amax = 0;
        for (int k = 0; k < n; k++) begin
            if (((tx[k] < 0) ? -tx[k] : tx[k]) > amax) amax = (tx[k] < 0) ? -tx[k] : tx[k];
        end
        send_tok(n);
        chk(in_ready == 1'b0, "R9 in_ready low after last", int'(in_ready), 0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!out_valid) @(negedge clk);
            chk(int'($signed(out_data)) == te[k], "R2 code", int'($signed(out_data)), te[k]);
            chk(out_last == (k == n - 1), "R7 out_last", int'(out_last), int'(k == n - 1));
            chk(int'(scale_amax) == amax, "R1 scale_amax", int'(scale_amax), amax);
            chk(scale_zero == (amax == 0), "R4 scale_zero", int'(scale_zero), int'(amax == 0));
            if (stall && (k % 2 == 1)) begin
                out_ready = 1'b0;
                @(negedge clk);
                chk(out_valid && int'($signed(out_data)) == te[k], "R8 held code",
                    int'($signed(out_data)), te[k]);
                out_ready = 1'b1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        chk(in_ready == 1'b1, "R7 input reopened", int'(in_ready), 1);
    endtask

    initial begin
        for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", WD_LIMIT, WD_LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(ovf_err == 1'b0, "R9 reset ovf_err", int'(ovf_err), 0);

        // table walk: R1 R2 R3 R4 R7 R8
        n = 0;
        for (int i = 0; i < NV; i++) begin
            tx[n] = VEC[i].x;
            te[n] = VEC[i].e;
            n++;
            if (VEC[i].lst) begin
                run_tok(n, (i % 2) == 1);
                n = 0;
            end
        end

        // R6: token of exactly DEPTH elements
        for (int k = 0; k < DEPTH; k++) begin
            tx[k] = k * 2000 - 15000;
            te[k] = mdl(tx[k], 15000);
        end
        outs_seen = 0;
        run_tok(DEPTH, 1'b1);
        chk(outs_seen > 0, "R6 full-depth token emitted", outs_seen, DEPTH);

        // R5: one element too many
        for (int k = 0; k <= DEPTH; k++) tx[k] = k + 1;
        err_seen  = 0;
        outs_seen = 0;
        send_tok(DEPTH + 1);
        chk(in_ready == 1'b1, "R5 input open after drop", int'(in_ready), 1);
        repeat (40) @(negedge clk);
        chk(err_seen == 1, "R5 ovf_err single pulse", err_seen, 1);
        chk(outs_seen == 0, "R5 no output for dropped token", outs_seen, 0);

        // R5: normal token after the drop
        tx[0] = 2; te[0] = 85;
        tx[1] = 3; te[1] = 127;
        run_tok(2, 1'b0);
        chk(err_seen == 1, "R5 no further error", err_seen, 1);

        // R3: lone most-negative input
        tx[0] = -32768; te[0] = -127;
        run_tok(1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule